// File: doc/BRIEF.md
# Shared-Chain Adder-Subtractor Logic Unit

This block is a purely combinational arithmetic and logic unit of parameterised width (32 bits by default). It takes two operands and a two-bit operation code. It returns the selected result, a zero indication, a signed overflow indication and the unsigned carry out of the top bit. It sits in the execute step of a simple processor datapath and also serves address arithmetic.

Addition and subtraction share one ripple chain of one-bit full adders, and each carry feeds the next position. For subtraction, every bit of the second operand goes through an XOR gate driven by the subtract control, which inverts the operand. The same control enters the chain as the carry into bit 0, so the chain computes A + ~B + 1. There is no separate subtractor. Bitwise AND and OR are formed next to the chain, and an output multiplexer picks among the four results.

The block has no states and no transitions. Its only "mode" is the operation code, applied in the same cycle as the operands.

Top module: `alu_core`

## Requirements
- R1: With operation code 2'b00 the result is the bitwise AND of A and B.
- R2: With operation code 2'b01 the result is the bitwise OR of A and B.
- R3: With operation code 2'b10 the result is A + B modulo 2^W.
- R4: With operation code 2'b11 the result is A - B modulo 2^W, formed as A + ~B + 1 on the shared chain.
- R5: The zero output is 1 exactly when every bit of the selected result is 0, for every operation code.
- R6: For 2'b10, the overflow output is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R7: For 2'b11, the overflow output is 1 exactly when A and B have different sign bits and the result's sign bit differs from that of A.
- R8: For 2'b10 the carry output is the unsigned carry out of bit W-1. For 2'b11 it is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R9: For 2'b00 and 2'b01, both the overflow output and the carry output are 0.
- R10: All outputs follow the inputs combinationally, with no clock and no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| op_i | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 subtract |
| result_o | output | W | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow (add/subtract only) |
| carry_o | output | 1 | Unsigned carry out of the top bit (add/subtract only) |

## Verification
The zero flag and the overflow flag can both be set by one operation. Adding the most negative value to itself wraps to zero with overflow and a carry out. Subtracting a value from itself gives zero with a carry and no overflow. The bench drives both cases among the corner vectors, alongside maximum-positive and minimum-negative operands and random vectors for each operation code. Each flag is compared separately against values the bench computes from operand signs and widened arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;
    always_comb begin
        half = x_i ^ y_i;
        s_o  = half ^ c_i;
        c_o  = (x_i & y_i) | (half & c_i);
    end
endmodule

// File: rtl/cond_invert.sv
module cond_invert #(
    parameter int W = 32
) (
    input  logic         inv_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar k = 0; k < W; k++) begin : g_xor
        assign q_o[k] = d_i[k] ^ inv_i;
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic [W:0]   carry_o
);
    assign carry_o[0] = cin_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        fa_cell u_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry_o[k]),
            .s_o (sum_o[k]),
            .c_o (carry_o[k+1])
        );
    end

    // R3/R4: the rippled chain must equal a widened behavioural sum
    always_comb begin
        assert_chain_sum_R3: assert ({carry_o[W], sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i}))
            else $error("chain sum mismatch");
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         ovf_o,
    output logic         carry_o
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic         sub;
    logic [W-1:0] b_mod;
    logic [W-1:0] sum;
    logic [W:0]   cy;
    logic         arith;

    assign op    = alu_op_e'(op_i);
    assign sub   = (op == OP_SUB);
    assign arith = (op == OP_ADD) || (op == OP_SUB);

    cond_invert #(.W(W)) u_inv (
        .inv_i (sub),
        .d_i   (b_i),
        .q_o   (b_mod)
    );

    ripple_chain #(.W(W)) u_chain (
        .x_i     (a_i),
        .y_i     (b_mod),
        .cin_i   (sub),
        .sum_o   (sum),
        .carry_o (cy)
    );

    always_comb begin
        unique case (op)
            OP_AND:  result_o = a_i & b_i;
            OP_OR:   result_o = a_i | b_i;
            OP_ADD:  result_o = sum;
            OP_SUB:  result_o = sum;
            default: result_o = '0;
        endcase
    end

    always_comb begin
        zero_o  = ~|result_o;
        ovf_o   = arith & (cy[W] ^ cy[MSB]);
        carry_o = arith & cy[W];
    end

    // R4: subtraction on the shared chain equals native subtraction
    // R9: flags stay low for logic operations
    // R7: subtract overflow only when operand signs differ
    always_comb begin
        if (op == OP_SUB) begin
            assert_sub_value_R4: assert (result_o == W'(a_i - b_i))
                else $error("subtract result mismatch");
        end
        if (!arith) begin
            assert_logic_flags_R9: assert (!ovf_o && !carry_o)
                else $error("flag raised on logic op");
        end
        if (op == OP_SUB && ovf_o) begin
            assert_sub_ovf_signs_R7: assert (a_i[MSB] != b_i[MSB])
                else $error("subtract overflow with equal signs");
        end
        if (op == OP_ADD && ovf_o) begin
            assert_add_ovf_signs_R6: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB])
                else $error("add overflow without sign flip");
        end
    end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W = 32;
    localparam int LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic [1:0]   op;
    logic [W-1:0] res;
    logic         zf, vf, cf;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] r;
        logic         z, v, c;
        logic [1:0]   op;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    alu_core #(.W(W)) dut (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(res), .zero_o(zf), .ovf_o(vf), .carry_o(cf)
    );

    function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] o);
        exp_t e;
        logic [W:0] wide;
        e.op = o; e.v = 0; e.c = 0;
        case (o)
            2'b00: e.r = x & y;
            2'b01: e.r = x | y;
            2'b10: begin
                wide = {1'b0, x} + {1'b0, y};
                e.r = wide[W-1:0];
                e.c = wide[W];
                e.v = (x[W-1] == y[W-1]) && (e.r[W-1] != x[W-1]);
            end
            default: begin
                e.r = x - y;
                e.c = (x >= y);
                e.v = (x[W-1] != y[W-1]) && (e.r[W-1] != x[W-1]);
            end
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    // driver: applies a vector on the rising edge and queues its expectation
    task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] o);
        @(posedge clk);
        a = x; b = y; op = o;
        sb.push_back(model(x, y, o));
    endtask

    function automatic string rtag(logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    // monitor: R10 combinational outputs sampled half a cycle after drive
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (res !== e.r) begin
                fails++;
                $display("FAIL %s result op=%b got %h exp %h", rtag(e.op), e.op, res, e.r);
            end
            if (zf !== e.z) begin
                fails++;
                $display("FAIL R5 zero op=%b got %b exp %b", e.op, zf, e.z);
            end
            if (vf !== e.v) begin
                fails++;
                $display("FAIL %s ovf op=%b got %b exp %b",
                         e.op == 2'b10 ? "R6" : (e.op == 2'b11 ? "R7" : "R9"), e.op, vf, e.v);
            end
            if (cf !== e.c) begin
                fails++;
                $display("FAIL %s carry op=%b got %b exp %b",
                         e.op[1] ? "R8" : "R9", e.op, cf, e.c);
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired at %0d cycles got hang exp done", cycles);
            finish_run();
        end
    end

    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONES = '1;

    initial begin
        a = '0; b = '0; op = 2'b00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state vector: zeros with AND -> zero flag, no flags (R1, R5, R9)
        drive('0, '0, 2'b00);
        // R1/R2 patterns
        drive(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00);
        drive(32'hAAAA_0000, 32'h5555_0000, 2'b00);
        drive(32'hAAAA_0000, 32'h5555_0001, 2'b01);
        drive('0, '0, 2'b01);
        // R9: logic ops with operands that would overflow if added
        drive(MAXP, MAXP, 2'b01);
        drive(MINN, MINN, 2'b00);
        // R3/R6/R8 add corners
        drive(MAXP, 32'd1, 2'b10);
        drive(MINN, MINN, 2'b10);      // zero + overflow + carry together
        drive(ONES, 32'd1, 2'b10);     // zero + carry, no overflow
        drive(MINN, ONES, 2'b10);
        drive(32'd5, 32'd7, 2'b10);
        // R4/R7/R8 subtract corners
        drive(32'd9, 32'd9, 2'b11);    // zero with carry
        drive(MINN, 32'd1, 2'b11);     // overflow
        drive(MAXP, ONES, 2'b11);      // overflow
        drive('0, 32'd1, 2'b11);       // borrow
        drive(MINN, MAXP, 2'b11);
        drive('0, MINN, 2'b11);
        // random vectors per operation
        for (int i = 0; i < 400; i++) begin
            drive($urandom, $urandom, 2'(i % 4));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        finish_run();
    end
endmodule